// File: doc/BRIEF.md
# Bit-addressable peripheral register space

This block is the peripheral register space of a small 8-bit CPU. Each cycle the CPU presents at most one access. The access has one of three styles. A port access uses a short I/O address. A load/store access uses a data-space address. A single-bit operation sets, clears or tests one bit of a low I/O register. The block translates the address, checks that the address region is legal for the access style, and applies the write with bit-level masking. It returns read data, a bit-test result and an error strobe in the same cycle.

The space holds three general-purpose storage registers and one event-flag register. The flag bits clear when a one is written to them. A peripheral-side input sets the flags. A single-bit set aimed at the flag register clears only the addressed flag, so software can acknowledge one event without losing the others.

Top module: `bitio_regspace`

## Requirements
- R1: A port access (`acc_kind_i`=0) uses I/O address `addr_i` and is legal only for addresses 0x00 to 0x3F. Above 0x3F it raises `err_o`, reads 0x00 and changes no register.
- R2: A load/store access (`acc_kind_i`=1) at data address 0x20 to 0x5F reaches the I/O register at that address minus 0x20. Data addresses below 0x20 raise `err_o` and change nothing.
- R3: General register 2 sits at data address 0xC4 in the extended region (0x60 to 0xFF). That region is reachable only by load/store. A port or bit access at the same numeric address is out of range.
- R4: A bit operation (`acc_kind_i`=2) is legal only for I/O addresses 0x00 to 0x1F. Above that it raises `err_o`, gives `bit_val_o`=0 and changes no register. Kind code 3 is always rejected the same way.
- R5: The event-flag register is at I/O address 0x16, with flags in bits 4:0. On a byte write, each flag whose data bit is 1 clears, and each flag whose data bit is 0 keeps its value.
- R6: A bit write (`acc_write_i`=1) with `bit_set_i`=1 on the flag register clears only flag `bit_sel_i`. With `bit_set_i`=0 it leaves every flag unchanged.
- R7: General register 0 (I/O 0x1E), register 1 (I/O 0x2A) and register 2 hold any byte written to them. A bit write on register 0 sets or clears only bit `bit_sel_i`, according to `bit_set_i`.
- R8: Flag-register bits 7:5 always read as zero, whatever is written or signalled.
- R9: A write to a legal but unmapped address raises `err_o` and stores nothing. A read from one returns 0x00 without `err_o`.
- R10: A bit test (`acc_kind_i`=2, `acc_write_i`=0) returns the selected bit on `bit_val_o` combinationally, in the same cycle.
- R11: A one on `flag_set_i[n]` sets flag n at the next edge, even if the CPU clears flag n in the same cycle.
- R12: While `rst_ni` is low, every register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is present this cycle |
| acc_kind_i | input | 2 | 0 port, 1 load/store, 2 bit operation, 3 invalid |
| acc_write_i | input | 1 | 1 write / bit write, 0 read / bit test |
| addr_i | input | 8 | I/O address (port, bit) or data address (load/store) |
| wdata_i | input | 8 | Byte write data |
| bit_sel_i | input | 3 | Bit position for bit operations |
| bit_set_i | input | 1 | Bit write value: 1 set, 0 clear |
| flag_set_i | input | 8 | Peripheral flag-set pulses; bits 7:5 unused |
| rdata_o | output | 8 | Byte read data, 0 when not a legal mapped read |
| bit_val_o | output | 1 | Bit-test result |
| err_o | output | 1 | Illegal region or unmapped write |

## Verification
The assertions assume at most one access per cycle. They also assume that the access fields are stable from the falling edge up to the next rising edge, so the combinational outputs and the register update see the same request. The bench drives every input at the falling edge and holds it for the whole cycle. The random stimulus draws kinds, addresses, bit positions and flag pulses freely, including kind 3 and out-of-range addresses, because the block must reject every such request itself. The address draws favour the mapped and boundary addresses, so that the rejection paths and the aliasing paths are both taken often.

// File: rtl/bitio_pkg.sv
package bitio_pkg;
  typedef enum logic [1:0] {
    KIND_PORT = 2'd0,
    KIND_MEM  = 2'd1,
    KIND_BIT  = 2'd2,
    KIND_RSVD = 2'd3
  } acc_kind_e;

  localparam int NUM_GP = 3;

  typedef struct packed {
    logic              illegal;
    logic              hit_flag;
    logic [NUM_GP-1:0] hit_gp;
  } dec_t;
endpackage

// File: rtl/bitio_decode.sv
module bitio_decode
  import bitio_pkg::*;
#(
  parameter int AW       = 8,
  parameter int PORT_TOP = 'h3F,
  parameter int BIT_TOP  = 'h1F,
  parameter int MEM_OFS  = 'h20,
  parameter int EXT_BASE = 'h60,
  parameter int FLAG_IO  = 'h16,
  parameter int GP0_IO   = 'h1E,
  parameter int GP1_IO   = 'h2A,
  parameter int GP2_DATA = 'hC4
) (
  input  acc_kind_e      kind_i,
  input  logic [AW-1:0]  addr_i,
  output dec_t           dec_o
);
  logic          io_ok;
  logic          ext_ok;
  logic [AW-1:0] io_addr;

  always_comb begin
    io_ok       = 1'b0;
    ext_ok      = 1'b0;
    io_addr     = '0;
    dec_o       = '0;
    unique case (kind_i)
      KIND_PORT: begin
        if (addr_i > AW'(PORT_TOP)) dec_o.illegal = 1'b1;
        else begin io_ok = 1'b1; io_addr = addr_i; end
      end
      KIND_MEM: begin
        if (addr_i < AW'(MEM_OFS)) dec_o.illegal = 1'b1;
        else if (addr_i < AW'(EXT_BASE)) begin
          io_ok   = 1'b1;
          io_addr = addr_i - AW'(MEM_OFS);
        end else ext_ok = 1'b1;
      end
      KIND_BIT: begin
        if (addr_i > AW'(BIT_TOP)) dec_o.illegal = 1'b1;
        else begin io_ok = 1'b1; io_addr = addr_i; end
      end
      default: dec_o.illegal = 1'b1;
    endcase
    dec_o.hit_flag  = io_ok && io_addr == AW'(FLAG_IO);
    dec_o.hit_gp[0] = io_ok && io_addr == AW'(GP0_IO);
    dec_o.hit_gp[1] = io_ok && io_addr == AW'(GP1_IO);
    dec_o.hit_gp[2] = ext_ok && addr_i == AW'(GP2_DATA);
  end
endmodule

// File: rtl/bitio_reg.sv
module bitio_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~mask_i) | (d_i & mask_i);
  end
endmodule

// File: rtl/bitio_flags.sv
module bitio_flags #(
  parameter int NF = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] set_i,
  output logic [NF-1:0] q_o
);
  // peripheral set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/bitio_regspace.sv
module bitio_regspace
  import bitio_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int NF       = 5,
  parameter int PORT_TOP = 'h3F,
  parameter int BIT_TOP  = 'h1F,
  parameter int MEM_OFS  = 'h20,
  parameter int EXT_BASE = 'h60,
  parameter int FLAG_IO  = 'h16,
  parameter int GP0_IO   = 'h1E,
  parameter int GP1_IO   = 'h2A,
  parameter int GP2_DATA = 'hC4,
  localparam int BW      = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic [1:0]    acc_kind_i,
  input  logic          acc_write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] bit_sel_i,
  input  logic          bit_set_i,
  input  logic [DW-1:0] flag_set_i,
  output logic [DW-1:0] rdata_o,
  output logic          bit_val_o,
  output logic          err_o
);
  acc_kind_e     kind;
  dec_t          dec;
  logic          hit_any, is_wr, byte_wr, bit_wr;
  logic [DW-1:0] bmask, gp_mask, gp_d, sel_val;
  logic [NF-1:0] flag_clr, flags_q;
  logic [DW-1:0] gp_q [NUM_GP];
  logic [NUM_GP*DW-1:0] gp_all;

  assign kind = acc_kind_e'(acc_kind_i);

  bitio_decode #(
    .AW(AW), .PORT_TOP(PORT_TOP), .BIT_TOP(BIT_TOP), .MEM_OFS(MEM_OFS),
    .EXT_BASE(EXT_BASE), .FLAG_IO(FLAG_IO), .GP0_IO(GP0_IO),
    .GP1_IO(GP1_IO), .GP2_DATA(GP2_DATA)
  ) i_decode (
    .kind_i(kind), .addr_i(addr_i), .dec_o(dec)
  );

  assign hit_any = dec.hit_flag | (|dec.hit_gp);
  assign is_wr   = acc_valid_i && acc_write_i && !dec.illegal;
  assign byte_wr = is_wr && kind != KIND_BIT;
  assign bit_wr  = is_wr && kind == KIND_BIT;
  assign bmask   = DW'(1) << bit_sel_i;
  assign gp_mask = byte_wr ? '1 : (bit_wr ? bmask : '0);
  assign gp_d    = byte_wr ? wdata_i : {DW{bit_set_i}};

  // bit write of 1 on flags clears that flag only, no read-modify-write
  always_comb begin
    flag_clr = '0;
    if (dec.hit_flag) begin
      if (byte_wr)                flag_clr = wdata_i[NF-1:0];
      else if (bit_wr && bit_set_i) flag_clr = bmask[NF-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    bitio_reg #(.DW(DW)) i_reg (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .mask_i(dec.hit_gp[g] ? gp_mask : '0),
      .d_i(gp_d), .q_o(gp_q[g])
    );
    assign gp_all[g*DW +: DW] = gp_q[g];
  end

  bitio_flags #(.NF(NF)) i_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(flag_clr), .set_i(flag_set_i[NF-1:0]), .q_o(flags_q)
  );

  always_comb begin
    sel_val = '0;
    if (dec.hit_flag) sel_val = DW'(flags_q);
    for (int i = 0; i < NUM_GP; i++)
      if (dec.hit_gp[i]) sel_val = gp_q[i];
  end

  assign rdata_o   = (acc_valid_i && !acc_write_i && kind != KIND_BIT) ? sel_val : '0;
  assign bit_val_o = (acc_valid_i && !acc_write_i && kind == KIND_BIT) ? sel_val[bit_sel_i] : 1'b0;
  assign err_o     = acc_valid_i && (dec.illegal || (acc_write_i && !hit_any));

  p_port_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && kind == KIND_PORT && addr_i > AW'(PORT_TOP)) |-> (err_o && rdata_o == '0));

  p_illegal_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && dec.illegal) |=> $stable(gp_all));

  p_zero_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && kind != KIND_BIT && dec.hit_flag &&
     wdata_i == '0 && flag_set_i == '0) |=> $stable(flags_q));

  p_only_bit_n_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && kind == KIND_BIT && dec.hit_flag) |=>
    ((($past(flags_q) & ~$past(bmask[NF-1:0])) & ~flags_q) == '0));

  p_rsvd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i && kind != KIND_BIT && dec.hit_flag) |->
    (rdata_o[DW-1:NF] == '0));

  p_unmapped_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i && !dec.illegal && !hit_any) |-> (rdata_o == '0 && !err_o));
endmodule

// File: tb/test_bitio_regspace.sv
module test_bitio_regspace;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] kind = '0;
  logic       wr = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [2:0] bsel = '0;
  logic       bset = 1'b0;
  logic [7:0] fset = '0;
  logic [7:0] rdata;
  logic       bval;
  logic       err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_gp [3];
  logic [4:0] m_fl;

  always #10 clk = ~clk;

  bitio_regspace i_bitio_regspace (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_kind_i(kind),
    .acc_write_i(wr), .addr_i(addr), .wdata_i(wdata), .bit_sel_i(bsel),
    .bit_set_i(bset), .flag_set_i(fset), .rdata_o(rdata), .bit_val_o(bval),
    .err_o(err)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // target: 0 none, 1 flags, 2..4 general registers 0..2
  function automatic void resolve(input logic [1:0] k, input logic [7:0] a,
                                  output bit ill, output int t);
    int io;
    ill = 0; t = 0; io = -1;
    case (k)
      2'd0: if (a > 8'h3F) ill = 1; else io = int'(a);
      2'd1: if (a < 8'h20) ill = 1;
            else if (a < 8'h60) io = int'(a) - 'h20;
            else if (a == 8'hC4) t = 4;
      2'd2: if (a > 8'h1F) ill = 1; else io = int'(a);
      default: ill = 1;
    endcase
    if (io == 'h16) t = 1;
    else if (io == 'h1E) t = 2;
    else if (io == 'h2A) t = 3;
  endfunction

  task automatic acc(input logic [1:0] k, input bit w, input logic [7:0] a,
                     input logic [7:0] d, input logic [2:0] b, input bit s,
                     input logic [7:0] fs, input string tag);
    bit ill; int t;
    logic [7:0] v, nv, e_rd;
    logic [4:0] clr;
    @(negedge clk);
    valid = 1'b1; kind = k; wr = w; addr = a; wdata = d; bsel = b; bset = s; fset = fs;
    #5;
    resolve(k, a, ill, t);
    v = (t == 1) ? {3'b000, m_fl} : (t >= 2) ? m_gp[t-2] : 8'h00;
    e_rd = (!w && k != 2'd2 && !ill) ? v : 8'h00;
    chk(tag, "err", {7'd0, err}, {7'd0, ill | (w && t == 0)});
    chk(tag, "rdata", rdata, e_rd);
    chk(tag, "bit_val", {7'd0, bval}, {7'd0, (!w && k == 2'd2 && !ill) ? v[b] : 1'b0});
    clr = '0;
    if (w && !ill) begin
      if (t == 1) begin
        if (k != 2'd2) clr = d[4:0];
        else if (s) clr = 5'(8'd1 << b);
      end else if (t >= 2) begin
        nv = m_gp[t-2];
        if (k != 2'd2) nv = d; else nv[b] = s;
        m_gp[t-2] = nv;
      end
    end
    m_fl = (m_fl & ~clr) | fs[4:0];
    @(posedge clk);
  endtask

  function automatic logic [7:0] pick_addr();
    logic [7:0] lst [12] = '{8'h16, 8'h1E, 8'h2A, 8'h36, 8'h3E, 8'h4A,
                             8'hC4, 8'h3F, 8'h40, 8'h1F, 8'h20, 8'h05};
    int r = int'($urandom % 16);
    if (r < 12) return lst[r];
    return 8'($urandom);
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string tags [4] = '{"R1", "R2", "R4", "R4"};
    void'($urandom(32'h5eed_1234));
    m_gp[0] = 0; m_gp[1] = 0; m_gp[2] = 0; m_fl = 0;
    repeat (3) @(posedge clk);
    #5;
    chk("R12", "idle rdata", rdata, 8'h00);
    chk("R12", "idle err", {7'd0, err}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R12: everything reads zero after reset
    acc(2'd0, 0, 8'h16, 0, 0, 0, 0, "R12");
    acc(2'd0, 0, 8'h1E, 0, 0, 0, 0, "R12");
    acc(2'd0, 0, 8'h2A, 0, 0, 0, 0, "R12");
    acc(2'd1, 0, 8'hC4, 0, 0, 0, 0, "R12");
    // R7 and R2: port write, load/store read through alias
    acc(2'd0, 1, 8'h1E, 8'hA5, 0, 0, 0, "R7");
    acc(2'd1, 0, 8'h3E, 0, 0, 0, 0, "R2");
    acc(2'd1, 1, 8'h4A, 8'h3C, 0, 0, 0, "R2");
    acc(2'd0, 0, 8'h2A, 0, 0, 0, 0, "R2");
    acc(2'd1, 1, 8'h10, 8'hFF, 0, 0, 0, "R2");
    // R3: extended region only by load/store
    acc(2'd1, 1, 8'hC4, 8'h96, 0, 0, 0, "R3");
    acc(2'd1, 0, 8'hC4, 0, 0, 0, 0, "R3");
    acc(2'd0, 1, 8'hC4, 8'h00, 0, 0, 0, "R3");
    acc(2'd1, 0, 8'hC4, 0, 0, 0, 0, "R3");
    // R1: port range
    acc(2'd0, 1, 8'h40, 8'h11, 0, 0, 0, "R1");
    acc(2'd0, 0, 8'h3F, 0, 0, 0, 0, "R1");
    // R7 and R10: bit ops on register 0
    acc(2'd2, 1, 8'h1E, 0, 3'd0, 0, 0, "R7");
    acc(2'd2, 1, 8'h1E, 0, 3'd6, 1, 0, "R7");
    acc(2'd2, 0, 8'h1E, 0, 3'd6, 0, 0, "R10");
    acc(2'd2, 0, 8'h1E, 0, 3'd0, 0, 0, "R10");
    acc(2'd0, 0, 8'h1E, 0, 0, 0, 0, "R7");
    // R4: bit op above 0x1F and kind 3 rejected
    acc(2'd2, 1, 8'h2A, 0, 3'd7, 1, 0, "R4");
    acc(2'd2, 0, 8'h2A, 0, 3'd2, 0, 0, "R4");
    acc(2'd3, 1, 8'h1E, 8'h00, 0, 0, 0, "R4");
    acc(2'd0, 0, 8'h2A, 0, 0, 0, 0, "R4");
    // R5: write-one-to-clear
    acc(2'd0, 0, 8'h16, 0, 0, 0, 8'h1F, "R11");
    acc(2'd0, 1, 8'h16, 8'h05, 0, 0, 0, "R5");
    acc(2'd0, 0, 8'h16, 0, 0, 0, 0, "R5");
    acc(2'd1, 1, 8'h36, 8'h00, 0, 0, 0, "R5");
    acc(2'd0, 0, 8'h16, 0, 0, 0, 0, "R5");
    // R6: bit set clears only that flag, bit clear no effect
    acc(2'd2, 1, 8'h16, 0, 3'd3, 1, 0, "R6");
    acc(2'd0, 0, 8'h16, 0, 0, 0, 0, "R6");
    acc(2'd2, 1, 8'h16, 0, 3'd1, 0, 0, "R6");
    acc(2'd2, 0, 8'h16, 0, 3'd1, 0, 0, "R6");
    acc(2'd2, 0, 8'h16, 0, 3'd3, 0, 0, "R6");
    // R11: set beats clear in the same cycle
    acc(2'd0, 1, 8'h16, 8'h1F, 0, 0, 8'h01, "R11");
    acc(2'd0, 0, 8'h16, 0, 0, 0, 0, "R11");
    // R8: reserved flag bits
    acc(2'd0, 0, 8'h16, 0, 0, 0, 8'hFF, "R8");
    acc(2'd1, 0, 8'h36, 0, 0, 0, 0, "R8");
    acc(2'd2, 0, 8'h16, 0, 3'd7, 0, 0, "R8");
    // R9: unmapped addresses
    acc(2'd0, 1, 8'h05, 8'h77, 0, 0, 0, "R9");
    acc(2'd0, 0, 8'h05, 0, 0, 0, 0, "R9");
    acc(2'd1, 1, 8'h90, 8'h77, 0, 0, 0, "R9");

    for (int n = 0; n < 3000; n++) begin
      logic [1:0] k = 2'($urandom % 4);
      logic [7:0] fs = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      acc(k, 1'($urandom), pick_addr(), 8'($urandom), 3'($urandom), 1'($urandom),
          fs, tags[k]);
    end
    // final readback of every register
    acc(2'd0, 0, 8'h16, 0, 0, 0, 0, "R5");
    acc(2'd0, 0, 8'h1E, 0, 0, 0, 0, "R7");
    acc(2'd0, 0, 8'h2A, 0, 0, 0, 0, "R7");
    acc(2'd1, 0, 8'hC4, 0, 0, 0, 0, "R3");
    @(negedge clk); valid = 1'b0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule